// File: doc/BRIEF.md
# NAND Read-Retry Mode Programmer

This block switches a flash device into one of several read-retry modes. On a start pulse it latches a mode index and sends a fixed stream of abstract flash operations to a downstream pin-level flash interface. It opens with a command that enters private parameter-setting mode. It then writes each vendor-private register as an address byte followed by a data byte. It closes with a command that applies the new settings.

The values for the registers come from a value table outside the block. The table is organised as one slice of `NREGS` bytes per mode. The block drives the table address and takes the byte back through a combinational read port. The register offsets are fixed inside the block. Operations move over a valid/ready stream, one at a time. The downstream side can flag a failure on any accepted operation. A failure aborts the sequence at once, and the block reports it with an error pulse. A complete sequence ends with a done pulse.

Top module: `retry_mode_loader`

## Requirements
- R1: While reset is asserted and right after it, `op_valid`, `busy`, `done` and `error` are all low.
- R2: The first operation after an accepted start is a command (`op_kind` = 0) carrying byte 0x36.
- R3: After the first operation, each register k, from 0 up to NREGS-1, gets two operations in order. The first is an address operation (`op_kind` = 1) carrying the offset. The second is a data-out operation (`op_kind` = 2). The offsets for k = 0..7 are 0xCC, 0xBF, 0xAA, 0xAB, 0xCD, 0xAD, 0xAE and 0xAF.
- R4: During the data-out operation of register k in mode m, `tbl_addr` equals m*NREGS + k, and `op_byte` equals the byte the table returns on `tbl_data`.
- R5: The last operation is a command (`op_kind` = 0) carrying byte 0x16. `done` is high for exactly one cycle, in the cycle after that command is accepted.
- R6: If `op_fail` is high while an operation is accepted, no further operation is offered. The apply command is not sent. `error` is high for exactly one cycle, in the cycle after that handshake, and `done` stays low.
- R7: A start with a mode index greater than or equal to NMODES produces a one-cycle `error` in the next cycle, and no operation is offered.
- R8: An offered operation keeps its kind, byte and table address unchanged until `op_ready` is high at a clock edge. Each such handshake moves exactly one operation.
- R9: A start pulse that arrives while `busy` is high has no effect on the running sequence or on the mode it uses.
- R10: `busy` is high from the cycle after an accepted start until the cycle in which `done` or `error` pulses, where it reads low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled only while idle |
| mode | input | MODE_W | Requested read-retry mode index |
| op_ready | input | 1 | Downstream accepts the offered operation |
| op_fail | input | 1 | Accepted operation failed (valid with the handshake) |
| tbl_data | input | 8 | Byte returned by the value table for `tbl_addr` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: apply command accepted |
| error | output | 1 | One-cycle pulse: bad mode or failed operation |
| op_valid | output | 1 | Operation offered |
| op_kind | output | 2 | 0 command, 1 address, 2 data-out |
| op_byte | output | 8 | Byte carried by the operation |
| tbl_addr | output | TBL_AW | Value table index |

## Verification
The bench targets four failure points. The first is the last register boundary: a design that stops early would skip 0xAF, and one that runs on would read past the mode's slice before the apply command. The second is failures injected on the enter command, in mid-register and on the apply command itself. A design that failed to abort would still send later operations or pulse done. The third is mode indices just at and above the mode count, where a missing range check would emit operations for a table slice that does not exist. The fourth is start pulses with other modes while busy, combined with stalled ready. A design that restarted or let its output slip would produce bytes from the wrong mode or repeat an operation.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_ENTER_PARAMS = 8'h36;
    localparam logic [BYTE_W-1:0] CMD_APPLY_PARAMS = 8'h16;

    typedef enum logic [1:0] {
        OPK_CMD  = 2'd0,
        OPK_ADDR = 2'd1,
        OPK_DOUT = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ENTER = 3'd1,
        PH_ADDR  = 3'd2,
        PH_DATA  = 3'd3,
        PH_APPLY = 3'd4
    } phase_e;

    // Fixed private register offsets, in write order.
    function automatic logic [BYTE_W-1:0] retry_reg_offset(input int unsigned k);
        case (k)
            0:       return 8'hCC;
            1:       return 8'hBF;
            2:       return 8'hAA;
            3:       return 8'hAB;
            4:       return 8'hCD;
            5:       return 8'hAD;
            6:       return 8'hAE;
            7:       return 8'hAF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rrm_tbl_index.sv
module rrm_tbl_index #(
    parameter int NREGS  = 8,
    parameter int MODE_W = 3,
    parameter int IDX_W  = 3,
    parameter int TBL_AW = 6
) (
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [IDX_W-1:0]  reg_idx,
    output logic [TBL_AW-1:0] tbl_addr
);
    localparam logic [TBL_AW-1:0] STRIDE = TBL_AW'(NREGS);

    always_comb begin
        tbl_addr = TBL_AW'(mode_sel) * STRIDE + TBL_AW'(reg_idx);
    end
endmodule

// File: rtl/rrm_op_build.sv
module rrm_op_build
    import rrm_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int IDX_W = 3
) (
    input  phase_e             phase,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [BYTE_W-1:0]  tbl_data,
    output logic               op_valid,
    output op_kind_e           op_kind,
    output logic [BYTE_W-1:0]  op_byte
);
    logic [BYTE_W-1:0] offs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_off
        assign offs[g] = retry_reg_offset(g);
    end

    always_comb begin
        op_valid = 1'b1;
        op_kind  = OPK_CMD;
        op_byte  = '0;
        case (phase)
            PH_ENTER: op_byte = CMD_ENTER_PARAMS;
            PH_ADDR: begin
                op_kind = OPK_ADDR;
                op_byte = offs[reg_idx];
            end
            PH_DATA: begin
                op_kind = OPK_DOUT;
                op_byte = tbl_data;
            end
            PH_APPLY: op_byte = CMD_APPLY_PARAMS;
            default:  op_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/rrm_seq.sv
module rrm_seq
    import rrm_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int NMODES = 6,
    parameter int MODE_W = 3,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              op_ready,
    input  logic              op_fail,
    output phase_e            phase,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [MODE_W-1:0] mode_q,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam logic [MODE_W:0]  MODE_LIM = (MODE_W+1)'(NMODES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NREGS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [MODE_W-1:0]   mode;
        logic                done;
        logic                error;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       xfer;
    logic       mode_ok;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.error = 1'b0;
        xfer      = (s_q.phase != PH_IDLE) && op_ready;
        mode_ok   = {1'b0, mode_in} < MODE_LIM;

        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                if (mode_ok) begin
                    s_d.phase = PH_ENTER;
                    s_d.mode  = mode_in;
                    s_d.idx   = '0;
                end else begin
                    s_d.error = 1'b1;
                end
            end
        end else if (xfer) begin
            if (op_fail) begin
                s_d.phase = PH_IDLE;
                s_d.error = 1'b1;
            end else begin
                case (s_q.phase)
                    PH_ENTER: begin
                        s_d.phase = PH_ADDR;
                        s_d.idx   = '0;
                    end
                    PH_ADDR:  s_d.phase = PH_DATA;
                    PH_DATA: begin
                        if (s_q.idx == IDX_LAST) begin
                            s_d.phase = PH_APPLY;
                        end else begin
                            s_d.phase = PH_ADDR;
                            s_d.idx   = s_q.idx + IDX_W'(1);
                        end
                    end
                    PH_APPLY: begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end
                    default:  s_d.phase = PH_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, idx: '0, mode: '0, done: 1'b0, error: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase   = s_q.phase;
    assign reg_idx = s_q.idx;
    assign mode_q  = s_q.mode;
    assign busy    = (s_q.phase != PH_IDLE);
    assign done    = s_q.done;
    assign error   = s_q.error;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_ready) |=> ($stable(s_q.phase) && $stable(s_q.idx)));

    // R7
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !mode_ok) |=> (error && !busy));

    // R6
    fail_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_ready && op_fail) |=> (error && !done && !busy));

    // R5
    done_after_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(s_q.phase == PH_APPLY && op_ready && !op_fail));

    // R9
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(s_q.mode));
endmodule

// File: rtl/retry_mode_loader.sv
module retry_mode_loader
    import rrm_pkg::*;
#(
    parameter int NREGS  = 8,
    parameter int NMODES = 6,
    localparam int MODE_W = (NMODES > 1) ? $clog2(NMODES) : 1,
    localparam int IDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int TBL_AW = (NREGS * NMODES > 1) ? $clog2(NREGS * NMODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic              op_ready,
    input  logic              op_fail,
    input  logic [7:0]        tbl_data,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              op_valid,
    output logic [1:0]        op_kind,
    output logic [7:0]        op_byte,
    output logic [TBL_AW-1:0] tbl_addr
);
    phase_e             phase;
    logic [IDX_W-1:0]   reg_idx;
    logic [MODE_W-1:0]  mode_q;
    op_kind_e           kind_w;

    rrm_seq #(
        .NREGS (NREGS),
        .NMODES(NMODES),
        .MODE_W(MODE_W),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (mode),
        .op_ready(op_ready),
        .op_fail (op_fail),
        .phase   (phase),
        .reg_idx (reg_idx),
        .mode_q  (mode_q),
        .busy    (busy),
        .done    (done),
        .error   (error)
    );

    rrm_tbl_index #(
        .NREGS (NREGS),
        .MODE_W(MODE_W),
        .IDX_W (IDX_W),
        .TBL_AW(TBL_AW)
    ) u_index (
        .mode_sel(mode_q),
        .reg_idx (reg_idx),
        .tbl_addr(tbl_addr)
    );

    rrm_op_build #(
        .NREGS(NREGS),
        .IDX_W(IDX_W)
    ) u_build (
        .phase   (phase),
        .reg_idx (reg_idx),
        .tbl_data(tbl_data),
        .op_valid(op_valid),
        .op_kind (kind_w),
        .op_byte (op_byte)
    );

    assign op_kind = kind_w;

    // R2
    enter_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_valid) |-> (op_kind == 2'd0 && op_byte == 8'h36));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(tbl_addr)));

    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !op_valid);
endmodule

// File: tb/retry_mode_loader_bench.sv
module retry_mode_loader_bench;
    localparam int NREGS  = 8;
    localparam int NMODES = 6;
    localparam int MODE_W = 3;
    localparam int TBL_AW = 6;
    localparam int NOPS   = 2 + 2 * NREGS;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, start, op_ready, op_fail;
    logic [MODE_W-1:0] mode;
    logic [7:0]        tbl_data;
    logic              busy, done, error, op_valid;
    logic [1:0]        op_kind;
    logic [7:0]        op_byte;
    logic [TBL_AW-1:0] tbl_addr;

    logic [7:0] tbl [0:NMODES*NREGS-1];
    assign tbl_data = tbl[tbl_addr];

    retry_mode_loader #(.NREGS(NREGS), .NMODES(NMODES)) u_retry_mode_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .op_ready(op_ready), .op_fail(op_fail), .tbl_data(tbl_data),
        .busy(busy), .done(done), .error(error), .op_valid(op_valid),
        .op_kind(op_kind), .op_byte(op_byte), .tbl_addr(tbl_addr)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_offset(input int k);
        logic [7:0] list [8] = '{8'hCC, 8'hBF, 8'hAA, 8'hAB, 8'hCD, 8'hAD, 8'hAE, 8'hAF};
        return list[k];
    endfunction

    function automatic int ref_kind(input int n);
        if (n == 0 || n == NOPS - 1) return 0;
        return ((n - 1) % 2 == 0) ? 1 : 2;
    endfunction

    function automatic logic [7:0] ref_byte(input int m, input int n);
        if (n == 0) return 8'h36;
        if (n == NOPS - 1) return 8'h16;
        if ((n - 1) % 2 == 0) return ref_offset((n - 1) / 2);
        return tbl[m * NREGS + (n - 1) / 2];
    endfunction

    function automatic string req_of(input int n);
        if (n == 0) return "R2";
        if (n == NOPS - 1) return "R5";
        return "R3";
    endfunction

    task automatic fill_table();
        for (int k = 0; k < NMODES * NREGS; k++) tbl[k] = 8'($urandom);
    endtask

    task automatic run_seq(input int m, input int fail_at, input int rdy_pct);
        int n = 0;
        int cyc = 0;
        bit hold = 1'b0;
        bit r, last, failed;
        logic [1:0] pk;
        logic [7:0] pb;
        logic [TBL_AW-1:0] pa;
        start = 1'b1; mode = MODE_W'(m); op_ready = 1'b0; op_fail = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        while (cyc < 5000) begin
            cyc++;
            if (hold)
                chk(op_valid && op_kind == pk && op_byte == pb && tbl_addr == pa,
                    "R8", "held op", {op_kind, op_byte}, {pk, pb});
            if (!op_valid) begin
                chk(1'b0, "R8", "op_valid dropped", 0, 1);
                return;
            end
            r = ($urandom % 100) < rdy_pct;
            op_ready = r;
            failed = (n == fail_at);
            op_fail = failed;
            // R9: stray starts with random modes while busy
            if ($urandom % 5 == 0) begin
                start = 1'b1; mode = MODE_W'($urandom);
            end else begin
                start = 1'b0;
            end
            if (r) begin
                chk(int'(op_kind) == ref_kind(n), req_of(n), "op kind", op_kind, ref_kind(n));
                chk(op_byte == ref_byte(m, n), (n > 0 && n < NOPS-1) ? "R3/R9" : req_of(n),
                    "op byte", op_byte, ref_byte(m, n));
                if (ref_kind(n) == 2)
                    chk(int'(tbl_addr) == m * NREGS + (n - 1) / 2, "R4", "table index",
                        tbl_addr, m * NREGS + (n - 1) / 2);
                n++;
                last = failed || (n == NOPS);
                @(negedge clk);
                op_ready = 1'b0; op_fail = 1'b0; start = 1'b0;
                if (last) begin
                    if (failed) begin
                        chk(error == 1'b1, "R6", "error after fail", error, 1);
                        chk(done == 1'b0, "R6", "no done after fail", done, 0);
                        chk(op_valid == 1'b0, "R6", "no op after fail", op_valid, 0);
                    end else begin
                        chk(done == 1'b1, "R5", "done pulse", done, 1);
                        chk(error == 1'b0, "R5", "no error", error, 0);
                    end
                    chk(busy == 1'b0, "R10", "busy at end", busy, 0);
                    @(negedge clk);
                    chk(done == 1'b0 && error == 1'b0, "R5", "pulse width", {done, error}, 0);
                    chk(op_valid == 1'b0, "R9", "no restart", op_valid, 0);
                    return;
                end
                hold = 1'b0;
            end else begin
                hold = 1'b1; pk = op_kind; pb = op_byte; pa = tbl_addr;
                @(negedge clk);
            end
        end
        chk(1'b0, "R5", "sequence did not end", n, NOPS);
    endtask

    task automatic bad_mode(input int m);
        start = 1'b1; mode = MODE_W'(m);
        @(negedge clk);
        start = 1'b0;
        chk(error == 1'b1, "R7", "error on bad mode", error, 1);
        chk(op_valid == 1'b0, "R7", "no op on bad mode", op_valid, 0);
        chk(busy == 1'b0, "R7", "not busy on bad mode", busy, 0);
        @(negedge clk);
        chk(error == 1'b0, "R7", "error one cycle", error, 0);
        chk(op_valid == 1'b0, "R7", "still no op", op_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C));
        rst_n = 1'b0; start = 1'b0; mode = '0; op_ready = 1'b0; op_fail = 1'b0;
        fill_table();
        repeat (3) @(negedge clk);
        chk(!op_valid && !busy && !done && !error, "R1", "reset state",
            {op_valid, busy, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!op_valid && !busy && !done && !error, "R1", "after reset",
            {op_valid, busy, done, error}, 0);

        run_seq(0, -1, 100);
        run_seq(NMODES - 1, -1, 30);
        bad_mode(NMODES);
        bad_mode(7);
        run_seq(2, 0, 60);
        run_seq(3, 5, 50);
        run_seq(1, NOPS - 1, 70);
        run_seq(4, NOPS - 2, 100);

        for (int t = 0; t < 30; t++) begin
            int m, f;
            fill_table();
            m = $urandom % NMODES;
            f = ($urandom % 4 == 0) ? int'($urandom % NOPS) : -1;
            run_seq(m, f, 20 + int'($urandom % 81));
            if ($urandom % 6 == 0) bad_mode(NMODES + int'($urandom % (8 - NMODES)));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule